// File: doc/BRIEF.md
# SDRAM Bank Timing Sequencer

This block drives a single SDRAM bank through its life cycle for a stream of
column accesses. Each access is handed over on a valid/ready handshake as a
direction bit, a row address and a column address. The sequencer decides
whether the bank already has that row open for that direction. On a match it
goes straight to the column command. On no match it closes the open row,
waits out the recovery time, opens the requested row and then issues the
column command. Every command goes out on a small command bus with its
address, one per clock. No command other than NOP is issued while a minimum
spacing is still running.

Each access ends with a two-cycle data phase, marked by a strobe. In the last
cycle of that phase the block reports whether the access hit the open row and
how many clock cycles it spent waiting before its column command. This makes
the cost of a row hit and the cost of a row change, or a change of direction,
visible at the pins. The three spacings are parameters counted in clock
cycles: precharge to activate, activate to precharge, and activate to column.

Top module: `sdram_bank_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, cmd_code is NOP, and data_strobe and access_done are 0.
- R2: cmd_code uses NOP=0, ACTIVATE=1, READ=2, WRITE=3 and PRECHARGE=4. cmd_row carries the row during ACTIVATE. cmd_col carries the column during READ or WRITE. The command is WRITE when req_write was 1 at acceptance and READ otherwise.
- R3: With no row open, an accepted access issues ACTIVATE in the cycle after acceptance and its column command exactly T_RCD cycles after the ACTIVATE. It reports hit 0 and wait T_RCD.
- R4: An access to the open row in the same direction as the last access issues its column command in the cycle after acceptance, with no ACTIVATE or PRECHARGE. It reports hit 1 and wait 0.
- R5: data_strobe is 1 in the column-command cycle and in the cycle after it. access_done is 1 only in that second cycle, and access_hit and access_wait are reported there.
- R6: An access to a different row issues PRECHARGE, then ACTIVATE with the new row exactly T_RP cycles later, then its column command T_RCD cycles after that. It reports hit 0.
- R7: An access to the open row in the opposite direction is handled like a row change, with PRECHARGE and ACTIVATE, and reports hit 0.
- R8: PRECHARGE is issued in cycle max(accept+1, last ACTIVATE+T_RAS). access_wait equals the number of cycles strictly between acceptance and the column command.
- R9: req_ready is 0 from the cycle after acceptance until the cycle after access_done. While ready is high only NOP is issued. Each access issues no commands other than the ones its case requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Sequencer can take an access this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_row | input | ROW_W | Row address of the access |
| req_col | input | COL_W | Column address of the access |
| cmd_code | output | 3 | Command issued this cycle |
| cmd_row | output | ROW_W | Row address, valid with ACTIVATE |
| cmd_col | output | COL_W | Column address, valid with READ/WRITE |
| data_strobe | output | 1 | Data phase cycle |
| access_done | output | 1 | Last data cycle of an access |
| access_hit | output | 1 | Access found its row open in the same direction |
| access_wait | output | WAIT_W | Cycles spent between acceptance and the column command |

## Verification
Every result is tied to the acceptance cycle. A row hit puts its column command one cycle after acceptance. A first access puts ACTIVATE one cycle after acceptance. A row change puts PRECHARGE at the later of the cycle after acceptance and the last ACTIVATE plus T_RAS. Each later command then follows at its exact spacing, and the hit flag and wait count appear one cycle after the column command. The bench numbers every clock, samples the ports at the falling edge, records the cycle in which each command appears, and compares those cycle numbers and the reported wait against values worked out from the last ACTIVATE cycle it saw. Accesses are spaced so that the T_RAS limit holds up the precharge in some cases and does not in others.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } bank_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_CLOSE,
        ST_ACTIVATE,
        ST_COLUMN,
        ST_BURST
    } bank_state_e;

    // timer slots
    localparam int unsigned TMR_RP  = 0;
    localparam int unsigned TMR_RAS = 1;
    localparam int unsigned TMR_RCD = 2;
    localparam int unsigned TMR_NUM = 3;

    function automatic int unsigned timer_width(input int unsigned cycles);
        return (cycles > 1) ? $clog2(cycles) : 1;
    endfunction

    function automatic bank_cmd_e column_cmd(input logic is_write);
        return is_write ? CMD_WR : CMD_RD;
    endfunction

    function automatic logic is_column_cmd(input bank_cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/bank_delay_timer.sv
module bank_delay_timer
    import bank_seq_pkg::*;
#(
    parameter int unsigned CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int unsigned CW = timer_width(CYCLES);
    localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // expired is high once CYCLES cycles have passed since the load cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker #(
    parameter int unsigned ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] open_row,
    input  logic             open_dir,
    input  logic [ROW_W-1:0] probe_row,
    input  logic             probe_dir,
    output logic             row_open,
    output logic             probe_hit
);
    logic [ROW_W-1:0] held_row;
    logic             held_dir;
    logic             held_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_row   <= '0;
            held_dir   <= 1'b0;
        end else if (open_en) begin
            held_valid <= 1'b1;
            held_row   <= open_row;
            held_dir   <= open_dir;
        end else if (close_en) begin
            held_valid <= 1'b0;
        end
    end

    assign row_open  = held_valid;
    assign probe_hit = held_valid && (held_row == probe_row) && (held_dir == probe_dir);

endmodule

// File: rtl/bank_wait_counter.sv
module bank_wait_counter #(
    parameter int unsigned WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [WAIT_W-1:0] value
);
    localparam logic [WAIT_W-1:0] TOP = {WAIT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            value <= '0;
        end else if (step && (value != TOP)) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/sdram_bank_sequencer.sv
module sdram_bank_sequencer
    import bank_seq_pkg::*;
#(
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned T_RP   = 3,
    parameter int unsigned T_RAS  = 8,
    parameter int unsigned T_RCD  = 3,
    parameter int unsigned WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [2:0]        cmd_code,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic              data_strobe,
    output logic              access_done,
    output logic              access_hit,
    output logic [WAIT_W-1:0] access_wait
);
    localparam int unsigned TMR_CYC [TMR_NUM] = '{T_RP, T_RAS, T_RCD};

    bank_state_e state, state_nx;
    bank_cmd_e   cmd;

    logic [ROW_W-1:0] pend_row;
    logic [COL_W-1:0] pend_col;
    logic             pend_wr;
    logic             pend_hit;

    logic               accept;
    logic               probe_hit;
    logic               row_open;
    logic               open_en;
    logic               close_en;
    logic [TMR_NUM-1:0] t_load;
    logic [TMR_NUM-1:0] t_exp;
    logic               col_issue;
    logic               wait_step;

    // spacing timers, one per constraint
    for (genvar g = 0; g < TMR_NUM; g++) begin : g_tmr
        bank_delay_timer #(
            .CYCLES(TMR_CYC[g])
        ) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .load   (t_load[g]),
            .expired(t_exp[g])
        );
    end

    bank_row_tracker #(
        .ROW_W(ROW_W)
    ) u_rows (
        .clk      (clk),
        .rst      (rst),
        .open_en  (open_en),
        .close_en (close_en),
        .open_row (pend_row),
        .open_dir (pend_wr),
        .probe_row(req_row),
        .probe_dir(req_write),
        .row_open (row_open),
        .probe_hit(probe_hit)
    );

    bank_wait_counter #(
        .WAIT_W(WAIT_W)
    ) u_wait (
        .clk  (clk),
        .rst  (rst),
        .clear(accept),
        .step (wait_step),
        .value(access_wait)
    );

    assign req_ready = (state == ST_IDLE) || (state == ST_OPEN);
    assign accept    = req_valid && req_ready;

    // request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_row <= '0;
            pend_col <= '0;
            pend_wr  <= 1'b0;
            pend_hit <= 1'b0;
        end else if (accept) begin
            pend_row <= req_row;
            pend_col <= req_col;
            pend_wr  <= req_write;
            pend_hit <= probe_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // command and next-state decode
    always_comb begin
        state_nx  = state;
        cmd       = CMD_NOP;
        open_en   = 1'b0;
        close_en  = 1'b0;
        t_load    = '0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nx = ST_ACTIVATE;
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    state_nx = probe_hit ? ST_COLUMN : ST_CLOSE;
                end
            end
            ST_CLOSE: begin
                if (t_exp[TMR_RAS]) begin
                    cmd              = CMD_PRE;
                    close_en         = 1'b1;
                    t_load[TMR_RP]   = 1'b1;
                    state_nx         = ST_ACTIVATE;
                end
            end
            ST_ACTIVATE: begin
                if (t_exp[TMR_RP]) begin
                    cmd              = CMD_ACT;
                    open_en          = 1'b1;
                    t_load[TMR_RAS]  = 1'b1;
                    t_load[TMR_RCD]  = 1'b1;
                    state_nx         = ST_COLUMN;
                end
            end
            ST_COLUMN: begin
                if (t_exp[TMR_RCD]) begin
                    cmd      = column_cmd(pend_wr);
                    state_nx = ST_BURST;
                end
            end
            ST_BURST: begin
                state_nx = ST_OPEN;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign col_issue = is_column_cmd(cmd);

    // waiting cycles: any cycle of the access before its column command
    assign wait_step = ((state == ST_CLOSE) || (state == ST_ACTIVATE) ||
                        (state == ST_COLUMN)) && !col_issue;

    assign cmd_code    = cmd;
    assign cmd_row     = (cmd == CMD_ACT) ? pend_row : '0;
    assign cmd_col     = col_issue ? pend_col : '0;
    assign data_strobe = col_issue || (state == ST_BURST);
    assign access_done = (state == ST_BURST);
    assign access_hit  = (state == ST_BURST) && pend_hit;

    logic unused_ok;
    assign unused_ok = row_open;

endmodule

// File: rtl/bank_seq_checker.sv
module bank_seq_checker #(
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned T_RP   = 3,
    parameter int unsigned T_RAS  = 8,
    parameter int unsigned T_RCD  = 3,
    parameter int unsigned WAIT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic [2:0]        cmd_code,
    input logic [ROW_W-1:0]  cmd_row,
    input logic [COL_W-1:0]  cmd_col,
    input logic              data_strobe,
    input logic              access_done,
    input logic              access_hit,
    input logic [WAIT_W-1:0] access_wait
);
    logic [15:0] since_act;
    logic [15:0] since_pre;
    logic        seen_act;
    logic        seen_pre;
    logic        is_col;

    assign is_col = (cmd_code == 3'd2) || (cmd_code == 3'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '0;
            since_pre <= '0;
            seen_act  <= 1'b0;
            seen_pre  <= 1'b0;
        end else begin
            if (cmd_code == 3'd1) begin
                since_act <= 16'd1;
                seen_act  <= 1'b1;
            end else if (since_act != 16'hFFFF) begin
                since_act <= since_act + 16'd1;
            end
            if (cmd_code == 3'd4) begin
                since_pre <= 16'd1;
                seen_pre  <= 1'b1;
            end else if (since_pre != 16'hFFFF) begin
                since_pre <= since_pre + 16'd1;
            end
        end
    end

    AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (rst)
        is_col |-> (seen_act && since_act >= T_RCD)); // R3
    AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd1 && seen_pre) |-> since_pre >= T_RP); // R6
    AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd4) |-> (seen_act && since_act >= T_RAS)); // R8
    AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (is_col && data_strobe) |=> (data_strobe && access_done)); // R5
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        access_done |-> (data_strobe && cmd_code == 3'd0 && !req_ready)); // R5
    AST_HIT_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (access_done && access_hit) |-> (access_wait == '0)); // R4
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cmd_code == 3'd0 && !data_strobe)); // R9
    AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_code == 3'd0) |-> (cmd_row == '0 && cmd_col == '0)); // R2
    AST_ONE_CMD_KIND: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_code == 3'd1, cmd_code == 3'd4, is_col})); // R2

endmodule

bind sdram_bank_sequencer bank_seq_checker #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .T_RP  (T_RP),
    .T_RAS (T_RAS),
    .T_RCD (T_RCD),
    .WAIT_W(WAIT_W)
) i_bank_seq_checker (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .cmd_code   (cmd_code),
    .cmd_row    (cmd_row),
    .cmd_col    (cmd_col),
    .data_strobe(data_strobe),
    .access_done(access_done),
    .access_hit (access_hit),
    .access_wait(access_wait)
);

// File: tb/test_sdram_bank_sequencer.sv
module test_sdram_bank_sequencer;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 10;
    localparam int T_RP   = 3;
    localparam int T_RAS  = 8;
    localparam int T_RCD  = 3;
    localparam int WAIT_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [2:0]        cmd_code;
    logic [ROW_W-1:0]  cmd_row;
    logic [COL_W-1:0]  cmd_col;
    logic              data_strobe;
    logic              access_done;
    logic              access_hit;
    logic [WAIT_W-1:0] access_wait;

    int  n_checks = 0;
    int  n_bad    = 0;
    int  cyc      = 0;
    bit  finished = 0;

    // requirement-level view of the bank
    bit  b_open = 0;
    int  b_row  = 0;
    bit  b_dir  = 0;
    int  b_act  = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_bank_sequencer #(
        .ROW_W(ROW_W), .COL_W(COL_W), .T_RP(T_RP),
        .T_RAS(T_RAS), .T_RCD(T_RCD), .WAIT_W(WAIT_W)
    ) i_sdram_bank_sequencer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_row(req_row), .req_col(req_col),
        .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .data_strobe(data_strobe), .access_done(access_done),
        .access_hit(access_hit), .access_wait(access_wait)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reset_test();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        check(cmd_code == 3'd0, "R1", "cmd in reset", cmd_code, 0);
        check(data_strobe == 1'b0 && access_done == 1'b0, "R1", "strobe/done in reset",
              {data_strobe, access_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && cmd_code == 3'd0, "R1", "ready/cmd after reset",
              {req_ready, cmd_code}, 8);
    endtask

    task automatic idle_gap(input int n);
        int quiet_bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cmd_code != 3'd0 || data_strobe) quiet_bad++;
        end
        check(quiet_bad == 0, "R9", "NOP-only cycles while idle", quiet_bad, 0);
    endtask

    task automatic run_access(input bit wr, input int row, input int col, input string tag);
        int  acc;
        int  c_act = -1;
        int  c_pre = -1;
        int  c_col = -1;
        int  n_cmd = 0;
        int  ready_bad = 0;
        int  guard = 0;
        bit  done = 0;
        bit  exp_hit;
        int  exp_wait;
        int  exp_cmds;
        int  pre_at = -1;
        int  seen_row = -1;
        int  seen_col = -1;
        int  seen_code = -1;
        bit  got_hit = 0;
        int  got_wait = -1;
        int  strobe_bad = 0;

        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        while (!req_ready) @(negedge clk);
        acc = cyc;

        if (!b_open) begin
            exp_hit  = 0;
            exp_wait = T_RCD;
            exp_cmds = 2;
        end else if (b_row == row && b_dir == wr) begin
            exp_hit  = 1;
            exp_wait = 0;
            exp_cmds = 1;
        end else begin
            exp_hit  = 0;
            pre_at   = (acc + 1 > b_act + T_RAS) ? acc + 1 : b_act + T_RAS;
            exp_wait = pre_at + T_RP + T_RCD - acc - 1;
            exp_cmds = 3;
        end

        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 300) begin
            if (req_ready) ready_bad++;
            case (cmd_code)
                3'd1: begin c_act = cyc; seen_row = int'(cmd_row); n_cmd++; end
                3'd4: begin c_pre = cyc; n_cmd++; end
                3'd2, 3'd3: begin
                    c_col = cyc; seen_col = int'(cmd_col); seen_code = int'(cmd_code); n_cmd++;
                    if (!data_strobe) strobe_bad++;
                end
                3'd0: ;
                default: n_cmd++;
            endcase
            if (access_done) begin
                done     = 1;
                got_hit  = access_hit;
                got_wait = int'(access_wait);
                if (!data_strobe) strobe_bad++;
                check(cyc == c_col + 1, "R5", {tag, " done one cycle after column"}, cyc, c_col + 1);
            end else begin
                @(negedge clk);
                guard++;
            end
        end

        check(done, "R5", {tag, " access completes"}, done, 1);
        check(strobe_bad == 0, "R5", {tag, " strobe in data phase"}, strobe_bad, 0);
        check(seen_code == (wr ? 3 : 2), "R2", {tag, " column command code"}, seen_code, wr ? 3 : 2);
        check(seen_col == col, "R2", {tag, " column address"}, seen_col, col);
        check(got_hit == exp_hit, exp_hit ? "R4" : (b_open && b_row == row ? "R7" : "R6"),
              {tag, " hit flag"}, got_hit, exp_hit);
        check(got_wait == exp_wait, "R8", {tag, " reported wait"}, got_wait, exp_wait);
        check(got_wait == c_col - acc - 1, "R8", {tag, " wait matches column cycle"},
              got_wait, c_col - acc - 1);
        check(ready_bad == 0, "R9", {tag, " ready low while busy"}, ready_bad, 0);
        check(n_cmd == exp_cmds, "R9", {tag, " command count"}, n_cmd, exp_cmds);

        if (exp_hit) begin
            check(c_col == acc + 1 && c_act < 0 && c_pre < 0, "R4", {tag, " direct column"},
                  c_col, acc + 1);
        end else begin
            check(seen_row == row, "R2", {tag, " row on activate"}, seen_row, row);
            check(c_col - c_act == T_RCD, "R3", {tag, " activate to column"}, c_col - c_act, T_RCD);
            if (!b_open) begin
                check(c_act == acc + 1, "R3", {tag, " activate after accept"}, c_act, acc + 1);
            end else begin
                check(c_pre == pre_at, "R8", {tag, " precharge cycle"}, c_pre, pre_at);
                check(c_act - c_pre == T_RP, b_row == row ? "R7" : "R6",
                      {tag, " precharge to activate"}, c_act - c_pre, T_RP);
            end
            b_act  = c_act;
            b_open = 1;
            b_row  = row;
            b_dir  = wr;
        end

        @(negedge clk);
        check(req_ready == 1'b1, "R9", {tag, " ready back after done"}, req_ready, 1);
    endtask

    initial begin
        reset_test();
        run_access(1'b0, 5, 17, "first read");             // R3
        run_access(1'b0, 9, 3, "early row change");         // R6 with T_RAS holding
        run_access(1'b0, 9, 4, "read hit");                 // R4
        run_access(1'b0, 9, 5, "second read hit");          // R4
        run_access(1'b1, 9, 6, "direction change");         // R7
        run_access(1'b1, 9, 7, "write hit");                // R4
        run_access(1'b1, 2, 1, "write row change");         // R6
        idle_gap(20);
        run_access(1'b0, 2, 8, "read after write late");    // R7, T_RAS long past
        idle_gap(12);
        run_access(1'b0, 4095, 1023, "far row change");     // R6, R8
        run_access(1'b0, 4095, 0, "edge hit");              // R4
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule